// File: doc/BRIEF.md
# SPI FIFO and Interrupt Controller

This block sits between a register bus and the serial shifter of an SPI controller. It buffers outgoing and incoming words in two 32-entry FIFOs. It reports their fill levels and flags, and it raises one interrupt line when a programmed level condition or a sticky error condition is enabled. Software pushes transmit words by writing one register and pops receive words by reading another. The shifter takes transmit words through a request/acknowledge pair and delivers received words with a valid strobe.

The level interrupts follow the fill levels and are not stored. The receive level interrupt is active while the receive level is above its threshold. The transmit level interrupt is active while the transmit level is at or below its threshold. The three error conditions are stored until software clears them, either one at a time or all together. Registers are selected by a 4-bit word index. Reads return data from the same cycle's state, and every side effect takes effect at the next clock edge.

Top module: `spi_fifo_irq`

## Requirements
- R1: Index 2 reads the transmit level and index 3 reads the receive level, each 0 to 32. A level changes at the clock edge that ends the access that moved it.
- R2: A write to index 0 appends a word to the transmit FIFO. `txReq` is high while that FIFO is not empty, and `txData` shows the oldest word, or 0 when the FIFO is empty. `txAck` removes that word, and it has no effect on an empty FIFO.
- R3: `rxValid` appends `rxData` to the receive FIFO. A read of index 1 returns the oldest received word and removes it.
- R4: Index 6 reads status: bit 4 receive full, bit 3 receive empty, bit 2 transmit empty, bit 1 transmit full, bit 0 the `shiftBusy` input.
- R5: A write to index 0 while the transmit FIFO holds 32 words is dropped and sets raw bit 1 (transmit overflow), even if `txAck` pops in the same cycle.
- R6: A read of index 1 while the receive FIFO is empty returns 0 and sets raw bit 2 (receive underflow).
- R7: `rxValid` while the receive FIFO holds 32 words drops the word and sets raw bit 3 (receive overflow).
- R8: A push and a pop on the same FIFO in one cycle, when the FIFO is neither empty nor full, leave its level unchanged.
- R9: Index 9 reads raw status. Bit 4 is set when the receive level is strictly greater than the 5-bit receive threshold at index 5. Bit 0 is set when the transmit level is at most the 5-bit transmit threshold at index 4. Both thresholds reset to 0.
- R10: Index 7 holds a 5-bit mask that resets to 0. Index 8 reads raw status ANDed with the mask, and `irq` is the OR of those bits.
- R11: Writing index 10 clears the sticky flags. Bit 3 clears transmit overflow, bit 2 clears receive overflow, bit 1 clears receive underflow and bit 0 clears all three. Zero bits have no effect. Raw bits 4 and 0 do not respond to the clear register. An error event in the same cycle as its clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register word index |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (pops on index 1) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, same cycle |
| irq | output | 1 | Interrupt, OR of masked status |
| txReq | output | 1 | Transmit FIFO holds a word |
| txData | output | 16 | Oldest transmit word |
| txAck | input | 1 | Shifter consumed the oldest transmit word |
| rxValid | input | 1 | Shifter delivers a received word |
| rxData | input | 16 | Received word |
| shiftBusy | input | 1 | Shifter is active, reported in status |

## Verification
Two things can happen in the same cycle. A sticky error event can coincide with a clear-register write that would erase it, and a FIFO can be pushed and popped together. The bench forces the first case by pulsing `rxValid` into a full receive FIFO in the very cycle that writes the clear-all bit, and it then expects the overflow flag to remain set while underflow is gone. The second case is provoked directly at a level of 31 and repeatedly by random stimulus. In every such cycle the reference model updates from the pre-edge state, and each read of a level, the raw status and the data is compared with it.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned IRQ_W  = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_TXDATA = 4'd0,
    A_RXDATA = 4'd1,
    A_TXLVL  = 4'd2,
    A_RXLVL  = 4'd3,
    A_TXTHR  = 4'd4,
    A_RXTHR  = 4'd5,
    A_STATUS = 4'd6,
    A_IMASK  = 4'd7,
    A_ISTAT  = 4'd8,
    A_IRAW   = 4'd9,
    A_ICLR   = 4'd10
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
  } fifoStrobe_t;

endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] popData,
  output logic [LVL_W-1:0]  level
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              doPush, doPop;

  assign doPush  = push && (level != FULL_LVL);
  assign doPop   = pop && (level != '0);
  assign popData = (level != '0) ? mem[rdPtr] : '0;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= rdPtr + PTR_W'(1);
      unique case ({doPush, doPop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strb,
  input  logic [DATA_W-1:0] txWdata,
  input  logic              txAck,
  output logic              txReq,
  output logic [DATA_W-1:0] txData,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxWdata,
  output logic [DATA_W-1:0] rxHead,
  output logic [LVL_W-1:0]  txLvl,
  output logic [LVL_W-1:0]  rxLvl
);

  spi_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txBuf (
    .clk(clk), .rstN(rstN),
    .push(strb.txPush), .pushData(txWdata),
    .pop(txAck), .popData(txData),
    .level(txLvl)
  );

  spi_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxBuf (
    .clk(clk), .rstN(rstN),
    .push(rxValid), .pushData(rxWdata),
    .pop(strb.rxPop), .popData(rxHead),
    .level(rxLvl)
  );

  assign txReq = (txLvl != '0);

endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned THR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [IRQ_W-1:0]  cfgWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output fifoStrobe_t       strb,
  input  logic [LVL_W-1:0]  txLvl,
  input  logic [LVL_W-1:0]  rxLvl,
  input  logic [DATA_W-1:0] rxHead,
  input  logic              rxValid,
  input  logic              shiftBusy
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [THR_W-1:0] txThr, rxThr;
  logic [IRQ_W-1:0] iMask, rawStat, status;
  logic             txOvf, rxOvf, rxUnf;
  logic             txFull, txEmpty, rxFull, rxEmpty;
  logic             txOvfEv, rxOvfEv, rxUnfEv;
  logic [3:0]       clr;

  assign txFull  = (txLvl == FULL_LVL);
  assign txEmpty = (txLvl == '0);
  assign rxFull  = (rxLvl == FULL_LVL);
  assign rxEmpty = (rxLvl == '0);

  assign strb.txPush = regWe && (regAddr == A_TXDATA);
  assign strb.rxPop  = regRe && (regAddr == A_RXDATA);

  assign txOvfEv = strb.txPush && txFull;
  assign rxOvfEv = rxValid && rxFull;
  assign rxUnfEv = strb.rxPop && rxEmpty;
  assign clr     = (regWe && (regAddr == A_ICLR)) ? cfgWdata[3:0] : 4'b0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txThr <= '0;
      rxThr <= '0;
      iMask <= '0;
      txOvf <= 1'b0;
      rxOvf <= 1'b0;
      rxUnf <= 1'b0;
    end else begin
      if (regWe && (regAddr == A_TXTHR)) txThr <= cfgWdata[THR_W-1:0];
      if (regWe && (regAddr == A_RXTHR)) rxThr <= cfgWdata[THR_W-1:0];
      if (regWe && (regAddr == A_IMASK)) iMask <= cfgWdata;
      // a new event outranks a clear in the same cycle
      txOvf <= txOvfEv | (txOvf & ~(clr[3] | clr[0]));
      rxOvf <= rxOvfEv | (rxOvf & ~(clr[2] | clr[0]));
      rxUnf <= rxUnfEv | (rxUnf & ~(clr[1] | clr[0]));
    end
  end

  assign rawStat = {rxLvl > LVL_W'(rxThr), rxOvf, rxUnf, txOvf,
                    txLvl <= LVL_W'(txThr)};
  assign status  = {rxFull, rxEmpty, txEmpty, txFull, shiftBusy};
  assign irq     = |(rawStat & iMask);

  always_comb begin
    regRdata = '0;
    if (regRe) begin
      unique case (regAddr)
        A_RXDATA: regRdata = rxHead;
        A_TXLVL:  regRdata = DATA_W'(txLvl);
        A_RXLVL:  regRdata = DATA_W'(rxLvl);
        A_TXTHR:  regRdata = DATA_W'(txThr);
        A_RXTHR:  regRdata = DATA_W'(rxThr);
        A_STATUS: regRdata = DATA_W'(status);
        A_IMASK:  regRdata = DATA_W'(iMask);
        A_ISTAT:  regRdata = DATA_W'(rawStat & iMask);
        A_IRAW:   regRdata = DATA_W'(rawStat);
        default:  regRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output logic              txReq,
  output logic [DATA_W-1:0] txData,
  input  logic              txAck,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              shiftBusy
);

  fifoStrobe_t       strb;
  logic [LVL_W-1:0]  txLvl, rxLvl;
  logic [DATA_W-1:0] rxHead;

  spi_fifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
    .cfgWdata(regWdata[IRQ_W-1:0]), .regRdata(regRdata),
    .irq(irq), .strb(strb),
    .txLvl(txLvl), .rxLvl(rxLvl), .rxHead(rxHead),
    .rxValid(rxValid), .shiftBusy(shiftBusy)
  );

  spi_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txWdata(regWdata), .txAck(txAck),
    .txReq(txReq), .txData(txData),
    .rxValid(rxValid), .rxWdata(rxData), .rxHead(rxHead),
    .txLvl(txLvl), .rxLvl(rxLvl)
  );

endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input fifoStrobe_t       strb,
  input logic              txAck,
  input logic              rxValid,
  input logic [LVL_W-1:0]  txLvl,
  input logic [LVL_W-1:0]  rxLvl,
  input logic [DATA_W-1:0] regRdata
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (txLvl <= FULL_LVL) && (rxLvl <= FULL_LVL)); // R1

  AST_TX_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txPush && (txLvl != FULL_LVL) && !txAck)
      |=> (txLvl == $past(txLvl) + LVL_W'(1))); // R2

  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txPush && (txLvl == FULL_LVL) && !txAck) |=> (txLvl == FULL_LVL)); // R5

  AST_RX_UNDER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxPop && (rxLvl == '0)) |-> (regRdata == '0)); // R6

  AST_RX_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && strb.rxPop && (rxLvl != '0) && (rxLvl != FULL_LVL))
      |=> $stable(rxLvl)); // R8

endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .txAck(txAck), .rxValid(rxValid),
  .txLvl(txLvl), .rxLvl(rxLvl), .regRdata(regRdata)
);

// File: tb/spi_fifo_irq_tb.sv
module spi_fifo_irq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irq, txReq;
  logic [15:0] txData;
  logic        txAck = 1'b0, rxValid = 1'b0, shiftBusy = 1'b0;
  logic [15:0] rxData = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [15:0] txQ[$];
  logic [15:0] rxQ[$];
  logic [4:0]  mTxThr = '0, mRxThr = '0, mMask = '0;
  bit          mTxOvf = 0, mRxOvf = 0, mRxUnf = 0;

  always #5 clk = ~clk;

  spi_fifo_irq u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .txReq(txReq),
    .txData(txData), .txAck(txAck), .rxValid(rxValid), .rxData(rxData),
    .shiftBusy(shiftBusy)
  );

  function automatic logic [4:0] expRaw();
    return {(rxQ.size() > int'(mRxThr)), mRxOvf, mRxUnf, mTxOvf,
            (txQ.size() <= int'(mTxThr))};
  endfunction

  function automatic logic [15:0] expRead(input logic [3:0] a);
    case (a)
      4'd1:  return (rxQ.size() > 0) ? rxQ[0] : 16'h0;
      4'd2:  return 16'(txQ.size());
      4'd3:  return 16'(rxQ.size());
      4'd4:  return 16'(mTxThr);
      4'd5:  return 16'(mRxThr);
      4'd6:  return {11'h0, rxQ.size() == 32, rxQ.size() == 0, txQ.size() == 0,
                     txQ.size() == 32, shiftBusy};
      4'd7:  return 16'(mMask);
      4'd8:  return 16'(expRaw() & mMask);
      4'd9:  return 16'(expRaw());
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] a);
    case (a)
      4'd1: return "R3";
      4'd2, 4'd3: return "R1";
      4'd6: return "R4";
      4'd7, 4'd8: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus/shifter cycle; got = read data sampled before the edge
  task automatic step(input logic we, input logic re, input logic [3:0] a,
                      input logic [15:0] wd, input logic ack, input logic rv,
                      input logic [15:0] rd, input logic busy,
                      output logic [15:0] got);
    bit txPushOk, txPopOk, rxPushOk, rxPopOk;
    @(negedge clk);
    regWe = we; regRe = re; regAddr = a; regWdata = wd;
    txAck = ack; rxValid = rv; rxData = rd; shiftBusy = busy;
    #4;
    got = regRdata;
    chk({15'h0, txReq}, {15'h0, txQ.size() > 0}, "R2 txReq");
    chk(txData, (txQ.size() > 0) ? txQ[0] : 16'h0, "R2 txData");
    chk({15'h0, irq}, {15'h0, |(expRaw() & mMask)}, "R10 irq");
    if (re) chk(got, expRead(a), tagOf(a));
    // model update from pre-edge state
    txPushOk = we && a == 4'd0 && txQ.size() < 32;
    txPopOk  = ack && txQ.size() > 0;
    rxPushOk = rv && rxQ.size() < 32;
    rxPopOk  = re && a == 4'd1 && rxQ.size() > 0;
    if (we && a == 4'd10) begin
      if (wd[3] || wd[0]) mTxOvf = 0;
      if (wd[2] || wd[0]) mRxOvf = 0;
      if (wd[1] || wd[0]) mRxUnf = 0;
    end
    if (we && a == 4'd0 && txQ.size() == 32) mTxOvf = 1;
    if (rv && rxQ.size() == 32) mRxOvf = 1;
    if (re && a == 4'd1 && rxQ.size() == 0) mRxUnf = 1;
    if (we && a == 4'd4) mTxThr = wd[4:0];
    if (we && a == 4'd5) mRxThr = wd[4:0];
    if (we && a == 4'd7) mMask = wd[4:0];
    if (txPopOk) void'(txQ.pop_front());
    if (txPushOk) txQ.push_back(wd);
    if (rxPopOk) void'(rxQ.pop_front());
    if (rxPushOk) rxQ.push_back(rd);
    @(posedge clk);
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [15:0] got);
    step(0, 1, a, 16'h0, 0, 0, 16'h0, 0, got);
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [15:0] d);
    logic [15:0] g;
    step(1, 0, a, d, 0, 0, 16'h0, 0, g);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    logic [15:0] g;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // reset state
    rdReg(4'd2, g); chk(g, 16'h0, "R1 reset tx level");
    rdReg(4'd6, g); chk(g, 16'h000C, "R4 reset status");
    rdReg(4'd9, g); chk(g, 16'h0001, "R9 reset raw");

    // transmit overflow
    for (int i = 0; i < 33; i++) wrReg(4'd0, 16'h1000 + 16'(i));
    rdReg(4'd2, g); chk(g, 16'd32, "R5 level stays 32");
    rdReg(4'd9, g); chk(16'(g[1]), 16'h1, "R5 tx overflow flag");
    wrReg(4'd10, 16'h0);
    rdReg(4'd9, g); chk(16'(g[1]), 16'h1, "R11 zero write keeps flag");
    wrReg(4'd10, 16'h8);
    rdReg(4'd9, g); chk(16'(g[1]), 16'h0, "R11 bit3 clears tx overflow");
    for (int i = 0; i < 32; i++) step(0, 0, 4'd0, 0, 1, 0, 0, 0, g);
    step(0, 0, 4'd0, 0, 1, 0, 0, 0, g); // ack on empty ignored
    rdReg(4'd2, g); chk(g, 16'd0, "R2 drained");

    // receive underflow
    rdReg(4'd1, g); chk(g, 16'h0, "R6 empty pop returns 0");
    rdReg(4'd9, g); chk(16'(g[2]), 16'h1, "R6 underflow flag");

    // receive overflow racing a clear-all
    for (int i = 0; i < 32; i++) step(0, 0, 4'd0, 0, 0, 1, 16'h2000 + 16'(i), 0, g);
    step(1, 0, 4'd10, 16'h1, 0, 1, 16'hDEAD, 0, g);
    rdReg(4'd9, g);
    chk(16'(g[3]), 16'h1, "R7 overflow set despite same-cycle clear (R11)");
    chk(16'(g[2]), 16'h0, "R11 clear-all removed underflow");
    rdReg(4'd3, g); chk(g, 16'd32, "R7 dropped word");

    // same-cycle push and pop
    rdReg(4'd1, g); chk(g, 16'h2000, "R3 oldest word");
    step(0, 1, 4'd1, 0, 0, 1, 16'h3333, 0, g);
    rdReg(4'd3, g); chk(g, 16'd31, "R8 level unchanged");

    // thresholds and mask
    wrReg(4'd5, 16'd30);
    rdReg(4'd9, g); chk(16'(g[4]), 16'h1, "R9 rx level 31 > 30");
    wrReg(4'd5, 16'd31);
    rdReg(4'd9, g); chk(16'(g[4]), 16'h0, "R9 rx level 31 not > 31");
    wrReg(4'd7, 16'h08);
    rdReg(4'd8, g); chk(g, 16'h0008, "R10 masked overflow");
    wrReg(4'd10, 16'h1F);
    rdReg(4'd9, g); chk(16'(g[0]), 16'h1, "R11 level bit unaffected by clear");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 99);
      logic we = 0, re = 0, ack, rv, busy;
      logic [3:0] a = 4'd0;
      logic [15:0] wd = 16'($urandom());
      ack = ($urandom_range(0, 3) == 0);
      rv = ($urandom_range(0, 2) == 0);
      busy = 1'($urandom());
      if (op < 30) begin we = 1; a = 4'd0; end
      else if (op < 70) begin re = 1; a = 4'($urandom_range(0, 11)); end
      else if (op < 80) begin re = 1; a = 4'd1; end
      else if (op < 84) begin we = 1; a = 4'd10; wd = 16'($urandom_range(0, 15)); end
      else if (op < 90) begin we = 1; a = 4'($urandom_range(4, 5)); end
      else if (op < 93) begin we = 1; a = 4'd7; end
      step(we, re, a, wd, ack, rv, 16'($urandom()), busy, g);
    end
    finish();
  end

endmodule